// File: doc/BRIEF.md
# PLL Lock-Aware Clock Switch

This block gates the clock that feeds the memory controller while the chip wakes from power-down. The core may start running as soon as the PLL begins to oscillate, before the PLL has settled. So the block first passes only one PLL cycle in every eight, which gives a slow clock that is safe to use. Once the PLL reports lock, the block moves to passing every PLL cycle. It makes this change only at the end of a divided period, so the controller never sees a shortened clock pulse.

The block runs on the PLL clock. Its output is a clock-enable, meant for an integrated clock gate further down the clock tree. The lock indication comes in from the analog side without any timing relation to the PLL clock, so the block synchronises it. Software reads a status word from the block. That word holds the lock bit, an interrupt flag that is set when lock is gained, and a timeout error flag. The error flag is set when lock does not arrive within a budget of about 2 ms (40960 cycles at 20.48 MHz). The budget is counted in clock cycles, and it is chosen separately for each reference source: the always-on low-power oscillator or the precision source. The block latches the source select when it wakes.

Top module: `pll_lock_clk_switch`

## Requirements
- R1: While rst_n is low, clk_en is 0 and every bit of status is 0.
- R2: A cycle that samples pwr_up low leaves clk_en at 0 in the next cycle, whatever state the block was in. A cycle that samples pwr_up high while the block is powered down starts acquisition.
- R3: During acquisition, clk_en is 1 for exactly one cycle in every DIV (default 8) cycles. With the clock edge that starts acquisition counted as edge 1, the first pulse follows edge DIV.
- R4: The block moves to full rate only at the clock edge that ends a cycle in which clk_en pulsed during acquisition, and only if the synchronised lock was already 1 in that cycle. From then on, clk_en is 1 in every cycle and status bit 3 (full rate) reads 1.
- R5: Status bit 1 shows pll_lock after a synchroniser of SYNC_STAGES flops (default 2). A change to pll_lock therefore appears after two rising edges.
- R6: Status bit 0 (interrupt flag) is set by the edge that follows a rising edge of the synchronised lock. It stays set until a cycle with clr_wr=1 and clr_mask bit 0 set. If a set and a clear fall in the same cycle, the set wins.
- R7: If the synchronised lock falls while the block is at full rate, the block returns to acquisition with a fresh phase. The first divided pulse then comes DIV cycles later, and status bit 3 reads 0.
- R8: Status bit 2 (timeout error) is set once the block has spent the limit number of cycles in acquisition without synchronised lock. The limit is TMO_LP_CYC when the latched source is 0 and TMO_PREC_CYC when it is 1. The bit is cleared by a cycle with clr_wr=1 and clr_mask bit 2 set, or by a new wake-up. If a set and a clear fall in the same cycle, the set wins.
- R9: Status bit 4 holds src_sel as it was sampled at wake-up (0 means the low-power oscillator, 1 means the precision source). Later changes to src_sel have no effect until the next wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | 1 while the PLL is powered and oscillating |
| pll_lock | input | 1 | Lock indication from the PLL, asynchronous to clk |
| src_sel | input | 1 | Reference source select: 0 low-power oscillator, 1 precision |
| clr_wr | input | 1 | Strobe for a write-one-to-clear of the status flags |
| clr_mask | input | 5 | Bits to clear; only bit 0 and bit 2 have an effect |
| clk_en | output | 1 | Enable for the memory-controller clock gate |
| status | output | 5 | {source, full rate, timeout error, lock, interrupt} |

## Verification
Two events can fall in the same cycle: a flag being raised by hardware and the same flag being cleared by software. For the interrupt flag, the bench raises pll_lock and then places the clear strobe in the cycle whose closing edge sees the new synchronised lock. The flag must read 1 afterwards, and a later clear on its own must drop it. For the timeout flag, the bench starts a clear strobe in the last cycle before the acquisition limit runs out. The flag must read 1, which shows that the set wins over the clear.

// File: rtl/cksw_pkg.sv
package cksw_pkg;

   typedef enum logic [1:0] {
      CK_OFF  = 2'd0,
      CK_ACQ  = 2'd1,
      CK_FULL = 2'd2
   } ck_state_e;

   localparam int STAT_W   = 5;
   localparam int ST_IRQ   = 0;
   localparam int ST_LOCK  = 1;
   localparam int ST_TMO   = 2;
   localparam int ST_FULL  = 3;
   localparam int ST_SRC   = 4;

endpackage

// File: rtl/cksw_sync.sv
module cksw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cksw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cksw_div_phase.sv
module cksw_div_phase #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tap
);

   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("cksw_div_phase: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (!run) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
      end else begin : g_modn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!run)         cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assign tap = run && (cnt == LAST);

   // R3
   tap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap |=> !tap);

endmodule

// File: rtl/cksw_lock_timer.sv
module cksw_lock_timer #(
   parameter int LIM_LP   = 40960,
   parameter int LIM_PREC = 40960
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic locked,
   input  logic src,
   output logic expire
);

   localparam int LMAX = (LIM_LP > LIM_PREC) ? LIM_LP : LIM_PREC;
   localparam int TW   = $clog2(LMAX + 1);

   generate
      if (LIM_LP < 1 || LIM_PREC < 1) begin : g_bad_lim
         $error("cksw_lock_timer: limits must be positive");
      end
   endgenerate

   logic [TW-1:0] tmr;
   logic [TW-1:0] lim;

   assign lim = src ? TW'(LIM_PREC) : TW'(LIM_LP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tmr <= '0;
      else if (!active)    tmr <= '0;
      else if (tmr != lim) tmr <= tmr + 1'b1;
   end

   assign expire = active && !locked && (tmr == lim - 1'b1);

   // R8
   tmo_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

endmodule

// File: rtl/cksw_status.sv
module cksw_status
   import cksw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              full,
   input  logic              wake,
   input  logic              expire,
   input  logic              src_sel,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_mask,
   output logic              src_q,
   output logic [STAT_W-1:0] status
);

   logic lock_q, irq, tmo_err;
   logic rise, clr_irq, clr_tmo;

   assign rise    = locked && !lock_q;
   assign clr_irq = clr_wr && clr_mask[ST_IRQ];
   assign clr_tmo = clr_wr && clr_mask[ST_TMO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         irq     <= 1'b0;
         tmo_err <= 1'b0;
         src_q   <= 1'b0;
      end else begin
         lock_q <= locked;
         if (rise)         irq <= 1'b1;
         else if (clr_irq) irq <= 1'b0;
         if (expire)                tmo_err <= 1'b1;
         else if (wake || clr_tmo)  tmo_err <= 1'b0;
         if (wake) src_q <= src_sel;
      end
   end

   always_comb begin
      status          = '0;
      status[ST_IRQ]  = irq;
      status[ST_LOCK] = locked;
      status[ST_TMO]  = tmo_err;
      status[ST_FULL] = full;
      status[ST_SRC]  = src_q;
   end

   // R6
   lock_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !lock_q) |=> irq);

   // R6
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_irq) |=> irq);

   // R8
   tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_err && !clr_tmo && !wake) |=> tmo_err);

   // R9
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wake |=> $stable(src_q));

endmodule

// File: rtl/pll_lock_clk_switch.sv
module pll_lock_clk_switch
   import cksw_pkg::*;
#(
   parameter int DIV          = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int TMO_LP_CYC   = 40960,
   parameter int TMO_PREC_CYC = 40960
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up,
   input  logic              pll_lock,
   input  logic              src_sel,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_mask,
   output logic              clk_en,
   output logic [STAT_W-1:0] status
);

   ck_state_e state, state_nx;
   logic      lock_s, tap, wake, expire, src_q;

   cksw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s)
   );

   cksw_div_phase #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(state == CK_ACQ), .tap(tap)
   );

   cksw_lock_timer #(.LIM_LP(TMO_LP_CYC), .LIM_PREC(TMO_PREC_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .active(state == CK_ACQ),
      .locked(lock_s), .src(src_q), .expire(expire)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         CK_OFF:  if (pwr_up) state_nx = CK_ACQ;
         CK_ACQ:  if (!pwr_up) state_nx = CK_OFF;
                  else if (lock_s && tap) state_nx = CK_FULL;
         CK_FULL: if (!pwr_up) state_nx = CK_OFF;
                  else if (!lock_s) state_nx = CK_ACQ;
         default: state_nx = CK_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= CK_OFF;
      else        state <= state_nx;
   end

   assign wake   = (state == CK_OFF) && pwr_up;
   assign clk_en = (state == CK_FULL) || tap;

   cksw_status u_stat (
      .clk(clk), .rst_n(rst_n), .locked(lock_s),
      .full(state == CK_FULL), .wake(wake), .expire(expire),
      .src_sel(src_sel), .clr_wr(clr_wr), .clr_mask(clr_mask),
      .src_q(src_q), .status(status)
   );

   // R4
   aligned_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CK_ACQ && !tap) |=> state != CK_FULL);

   // R2
   idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_up |=> !clk_en);

   // R7
   lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CK_FULL && !lock_s && pwr_up) |=> state == CK_ACQ);

   // R1
   always_comb begin
      if (!rst_n) begin
         reset_out_chk: assert (!clk_en || $isunknown(state));
      end
   end

endmodule

// File: tb/pll_lock_clk_switch_tb_top.sv
`timescale 1ns/1ps
module pll_lock_clk_switch_tb_top;

   localparam int DIV  = 8;
   localparam int LP   = 40;
   localparam int PREC = 72;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_up = 1'b0;
   logic       pll_lock = 1'b0;
   logic       src_sel = 1'b0;
   logic       clr_wr = 1'b0;
   logic [4:0] clr_mask = '0;
   logic       clk_en;
   logic [4:0] status;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pll_lock_clk_switch #(.DIV(DIV), .SYNC_STAGES(2),
                         .TMO_LP_CYC(LP), .TMO_PREC_CYC(PREC)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .pll_lock(pll_lock),
      .src_sel(src_sel), .clr_wr(clr_wr), .clr_mask(clr_mask),
      .clk_en(clk_en), .status(status)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_idle();
      pwr_up = 1'b0; pll_lock = 1'b0;
      step(4);
      clr_wr = 1'b1; clr_mask = 5'b00101;
      step(1);
      clr_wr = 1'b0; clr_mask = '0;
   endtask

   task automatic wake_up(input logic src);
      src_sel = src; pwr_up = 1'b1;
      step(1);
   endtask

   task automatic t_reset();
      step(2);
      check("R1 clk_en in reset", int'(clk_en), 0);
      check("R1 status in reset", int'(status), 0);
      rst_n = 1'b1;
      step(2);
      check("R2 clk_en while down", int'(clk_en), 0);
   endtask

   task automatic t_acq_pattern();
      go_idle();
      wake_up(1'b0);
      for (int i = 0; i < 24; i++) begin
         check($sformatf("R3 divided pulse s%0d", i), int'(clk_en),
               ((i % DIV) == DIV - 1) ? 1 : 0);
         if (i == 5) check("R4 not full while unlocked", int'(status[3]), 0);
         step(1);
      end
   endtask

   task automatic t_switch_mid();
      go_idle();
      wake_up(1'b0);
      step(2);
      pll_lock = 1'b1;
      step(1);
      check("R5 lock after one edge", int'(status[1]), 0);
      step(1);
      check("R5 lock after two edges", int'(status[1]), 1);
      check("R3 no pulse s4", int'(clk_en), 0);
      step(3);
      check("R4 pulse s7", int'(clk_en), 1);
      check("R4 still divided s7", int'(status[3]), 0);
      step(1);
      check("R4 full rate s8", int'(status[3]), 1);
      for (int i = 0; i < 10; i++) begin
         check("R4 continuous enable", int'(clk_en), 1);
         step(1);
      end
   endtask

   task automatic t_switch_late();
      go_idle();
      wake_up(1'b0);
      step(6);
      pll_lock = 1'b1;
      step(1);
      check("R3 pulse s7", int'(clk_en), 1);
      step(1);
      check("R4 no switch at s8", int'(status[3]), 0);
      for (int i = 8; i < 15; i++) begin
         check("R4 divided until aligned", int'(clk_en), 0);
         step(1);
      end
      check("R4 pulse s15", int'(clk_en), 1);
      check("R4 still divided s15", int'(status[3]), 0);
      step(1);
      check("R4 full rate s16", int'(status[3]), 1);
      check("R4 enable s16", int'(clk_en), 1);
   endtask

   task automatic t_lock_loss();
      pll_lock = 1'b0;
      step(2);
      check("R7 enable before fall seen", int'(clk_en), 1);
      step(1);
      check("R7 back to divided", int'(status[3]), 0);
      for (int i = 0; i < 7; i++) begin
         check("R7 fresh phase gap", int'(clk_en), 0);
         step(1);
      end
      check("R7 first pulse after loss", int'(clk_en), 1);
   endtask

   task automatic t_powerdown();
      go_idle();
      wake_up(1'b0);
      pll_lock = 1'b1;
      step(12);
      check("R4 full before power-down", int'(status[3]), 1);
      pwr_up = 1'b0;
      step(1);
      check("R2 enable off after power-down", int'(clk_en), 0);
      check("R2 full bit off", int'(status[3]), 0);
      step(3);
      check("R2 stays off", int'(clk_en), 0);
   endtask

   task automatic t_timeout_lp();
      go_idle();
      wake_up(1'b0);
      step(LP - 1);
      check("R8 no error before limit", int'(status[2]), 0);
      step(1);
      check("R8 error at low-power limit", int'(status[2]), 1);
      step(5);
      check("R8 error held", int'(status[2]), 1);
      clr_wr = 1'b1; clr_mask = 5'b00100;
      step(1);
      clr_wr = 1'b0; clr_mask = '0;
      check("R8 error cleared", int'(status[2]), 0);
      check("R6 irq untouched by error clear", int'(status[0]), 0);
   endtask

   task automatic t_timeout_prec_src();
      go_idle();
      wake_up(1'b1);
      src_sel = 1'b0;
      step(3);
      check("R9 source latched", int'(status[4]), 1);
      step(LP);
      check("R8 precision limit not yet", int'(status[2]), 0);
      step(PREC - LP - 4);
      check("R8 before precision limit", int'(status[2]), 0);
      step(1);
      check("R8 error at precision limit", int'(status[2]), 1);
      check("R9 source ignores change", int'(status[4]), 1);
      pwr_up = 1'b0;
      step(2);
      wake_up(1'b0);
      check("R8 wake clears error", int'(status[2]), 0);
      check("R9 source relatched", int'(status[4]), 0);
   endtask

   task automatic t_err_race();
      go_idle();
      wake_up(1'b0);
      step(LP - 1);
      clr_wr = 1'b1; clr_mask = 5'b00100;
      step(1);
      clr_wr = 1'b0; clr_mask = '0;
      check("R8 set wins over clear", int'(status[2]), 1);
   endtask

   task automatic t_irq_race();
      go_idle();
      check("R6 irq clear at start", int'(status[0]), 0);
      pll_lock = 1'b1;
      step(2);
      check("R6 irq not yet", int'(status[0]), 0);
      clr_wr = 1'b1; clr_mask = 5'b00001;
      step(1);
      clr_wr = 1'b0; clr_mask = '0;
      check("R6 set wins over clear", int'(status[0]), 1);
      step(4);
      check("R6 irq held", int'(status[0]), 1);
      clr_wr = 1'b1; clr_mask = 5'b00001;
      step(1);
      clr_wr = 1'b0; clr_mask = '0;
      check("R6 irq cleared", int'(status[0]), 0);
      check("R5 lock still shown", int'(status[1]), 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_acq_pattern();
      t_switch_mid();
      t_switch_late();
      t_lock_loss();
      t_powerdown();
      t_timeout_lp();
      t_timeout_prec_src();
      t_err_race();
      t_irq_race();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

endmodule